// File: doc/BRIEF.md
# Single-Master Shared Bus Copy Controller

This block is the master side of a shared bus where one master and up to eight slaves sit on common lines. Only the master drives the address bus. The address bus is `ceil(log2 N)` bits wide. Each slave's enable is decoded from that address, so a slave that is not addressed takes no part in a transfer. The shared data lines are 16 bits wide. They are split into a return path (`bus_rdata`, driven by whichever slave is reading) and a master drive path (`bus_wdata` with its enable `bus_wdrv`).

A copy command names a source slave and a destination slave. The block moves one word between them in two bus cycles. In the first cycle it addresses the source, asserts that slave's read strobe, and latches the returned word into a holding register. In the second cycle it addresses the destination, drives the held word, and asserts that slave's write strobe. `cmd_busy` covers both cycles. `cmd_done` pulses for one clock once the write cycle is over.

Top module: `shared_bus_copier`

## Requirements
- R1: After reset, `cmd_busy`, `cmd_done`, `bus_wdrv` and every strobe are 0, and `bus_addr` is 0.
- R2: A `cmd_start` seen at a clock edge while not busy starts a copy. `cmd_busy` is 1 for exactly the two following cycles.
- R3: In the first busy cycle, `bus_addr` equals the source, only `slv_rd` bit *source* is 1, `slv_wr` is all zero, and `bus_wdrv` is 0.
- R4: The word on `bus_rdata` at the end of the read cycle is held and appears on `bus_wdata` for the whole write cycle.
- R5: In the second busy cycle, `bus_addr` equals the destination, only `slv_wr` bit *destination* is 1, `slv_rd` is all zero, and `bus_wdrv` is 1.
- R6: In no cycle are the master drive and any slave read strobe active together. At most one strobe of all `slv_rd`/`slv_wr` bits is high.
- R7: `cmd_done` is 1 for exactly the one cycle after the write cycle, and 0 otherwise.
- R8: A `cmd_start` while busy is ignored. The running copy keeps its operands and no further copy follows.
- R9: A copy whose source equals its destination still takes both cycles and leaves that slave's word unchanged.
- R10: While not busy, no slave strobe is active and the master does not drive the data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Request a copy |
| cmd_src | input | AW | Source slave index |
| cmd_dst | input | AW | Destination slave index |
| cmd_busy | output | 1 | Copy in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | AW | Master-driven address bus |
| bus_rdata | input | DW | Data lines as driven by the reading slave |
| bus_wdata | output | DW | Data the master drives during a write |
| bus_wdrv | output | 1 | Master drives the data lines |
| slv_rd | output | N | Per-slave decoded read strobe |
| slv_wr | output | N | Per-slave decoded write strobe |

## Verification
The assertions check every cycle that only one data driver is active, that strobes are one-hot or idle, and that a read is always followed by a write. They also check that the written word is the one sampled in the previous cycle, and that busy and done have the right lengths. Only the bench's scenarios can show that specific source and destination indices reach the right strobe bits and that slave contents end up correct. The same holds for the same-slave copy, for a start issued mid-copy being ignored, and for back-to-back commands.

// File: rtl/shared_bus_copier.sv
module shared_bus_copier #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdrv,
  output logic [N-1:0]  slv_rd,
  output logic [N-1:0]  slv_wr
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} phase_t;

  phase_t        phase;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] hold_q;
  logic [N-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      hold_q   <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= (phase == S_WRITE);
      case (phase)
        S_IDLE:
          if (cmd_start) begin
            src_q <= cmd_src;
            dst_q <= cmd_dst;
            phase <= S_READ;
          end
        S_READ: begin
          hold_q <= bus_rdata;
          phase  <= S_WRITE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign cmd_busy  = (phase != S_IDLE);
  assign bus_addr  = (phase == S_READ)  ? src_q :
                     (phase == S_WRITE) ? dst_q : '0;
  assign bus_wdrv  = (phase == S_WRITE);
  assign bus_wdata = bus_wdrv ? hold_q : '0;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign sel[i]    = cmd_busy && (bus_addr == AW'(i));
    assign slv_rd[i] = sel[i] && (phase == S_READ);
    assign slv_wr[i] = sel[i] && (phase == S_WRITE);
  end

endmodule

// File: rtl/shared_bus_copier_chk.sv
module shared_bus_copier_chk #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_busy,
  input logic          cmd_done,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wdrv,
  input logic [N-1:0]  slv_rd,
  input logic [N-1:0]  slv_wr
);

  a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wdrv && (|slv_rd)));

  a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slv_rd, slv_wr}));

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|slv_rd) |=> ((|slv_wr) && bus_wdrv));

  a_r4_held_word: assert property (@(posedge clk) disable iff (!rst_n)
    (|slv_wr) |-> (bus_wdata == $past(bus_rdata)));

  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |=> (cmd_busy ##1 !cmd_busy));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(|slv_wr));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> (slv_rd == '0 && slv_wr == '0 && !bus_wdrv));

endmodule

bind shared_bus_copier shared_bus_copier_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
  .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .bus_wdrv(bus_wdrv),
  .slv_rd(slv_rd), .slv_wr(slv_wr)
);

// File: tb/shared_bus_copier_bench.sv
module shared_bus_copier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_start = 0;
  logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
  logic          cmd_busy, cmd_done, bus_wdrv;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata, bus_wdata;
  logic [N-1:0]  slv_rd, slv_wr;

  logic [DW-1:0] mem  [N];
  logic [DW-1:0] mdl  [N];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_copier #(.N(N), .DW(DW)) u_shared_bus_copier (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .bus_wdrv(bus_wdrv), .slv_rd(slv_rd), .slv_wr(slv_wr));

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N; i++) if (slv_rd[i]) bus_rdata = bus_rdata | mem[i];
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) if (slv_wr[i]) mem[i] <= bus_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [5:0] CMDS [8] = '{
    {3'd0, 3'd7}, {3'd7, 3'd1}, {3'd3, 3'd5}, {3'd5, 3'd2},
    {3'd1, 3'd0}, {3'd6, 3'd4}, {3'd2, 3'd6}, {3'd4, 3'd3}
  };

  task automatic copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input bit noise);
    logic [DW-1:0] w;
    w = mdl[s];
    @(negedge clk);
    cmd_start = 1; cmd_src = s; cmd_dst = d;
    @(negedge clk);
    if (noise) begin cmd_src = ~s; cmd_dst = ~d; end else cmd_start = 0;
    chk("R2 busy read", 32'(cmd_busy), 1);
    chk("R3 read addr", 32'(bus_addr), 32'(s));
    chk("R3 read strobe", 32'(slv_rd), 32'(1 << s));
    chk("R3 no write", 32'({slv_wr, bus_wdrv}), 0);
    @(negedge clk);
    chk("R2 busy write", 32'(cmd_busy), 1);
    chk(noise ? "R8 write addr kept" : "R5 write addr", 32'(bus_addr), 32'(d));
    chk("R5 write strobe", 32'(slv_wr), 32'(1 << d));
    chk("R5 drive", 32'({slv_rd, bus_wdrv}), 1);
    chk("R4 held word", 32'(bus_wdata), 32'(w));
    cmd_start = 0;
    mdl[d] = w;
    @(negedge clk);
    chk("R7 done", 32'(cmd_done), 1);
    chk("R2 busy end", 32'(cmd_busy), 0);
    chk(s == d ? "R9 same slave" : "R4 dest word", 32'(mem[d]), 32'(w));
    @(negedge clk);
    chk("R7 done low", 32'(cmd_done), 0);
    chk(noise ? "R8 no extra copy" : "R10 idle", 32'({cmd_busy, slv_rd, slv_wr, bus_wdrv}), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i] = 16'hA000 + 16'(i * 16'h0111);
      mdl[i] = mem[i];
    end
    #(CLK_PERIOD * 3);
    chk("R1 reset busy/done", 32'({cmd_busy, cmd_done, bus_wdrv}), 0);
    chk("R1 reset strobes", 32'({slv_rd, slv_wr}), 0);
    chk("R1 reset addr", 32'(bus_addr), 0);
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 8; k++) copy(CMDS[k][5:3], CMDS[k][2:0], 0);
    copy(3'd4, 3'd4, 0);
    copy(3'd2, 3'd5, 1);
    for (int i = 0; i < N; i++) chk("R9 final contents", 32'(mem[i]), 32'(mdl[i]));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule